// File: doc/BRIEF.md
# CSI-2 Packet Filter and Crop Window

This block sits directly behind a CSI-2 packet decoder. Each cycle it may receive one decoded item: a frame start, a line start, a frame end or a single pixel word. Each item carries a virtual channel number and a data type. The block keeps only pixels from enabled virtual channels and enabled packet classes (raw or YUV). It tracks the column and row of every accepted pixel and forwards only the pixels that fall inside a programmable rectangle.

It also turns frame starts and line starts into one-cycle vertical and horizontal sync pulses for the following stage. Each pulse comes only from the virtual channels picked by a one-hot selector. A small register port sets the window, the selectors and the enables. It also gives software a soft reset and a clock enable; while either is inactive, the block is silent.

Top module: `csi_crop`

## Requirements
- R1: After reset every register reads 0, and out_valid, out_vs and out_hs are 0.
- R2: Register map, all bits not listed reading 0:
  - Byte address 0x00: bit 0 is the soft reset and bit 1 is the clock enable.
  - Byte address 0x04: bits 3:0 enable VC0..VC3, and bits 20:16 form the class field. Bit 16 accepts raw and bit 17 accepts YUV.
  - 0x0C holds the column window: first column in bits 15:0, last column (width minus one) in bits 31:16.
  - 0x10 holds the row window in the same layout.
  - 0x1C holds the one-hot sync selectors: bits 19:16 pick the vertical sync channel and bits 23:20 pick the horizontal sync channel, with the lowest bit standing for VC0.
- R3: While the soft reset bit is 1 or the clock enable bit is 0, no output is produced and the column, row and in-line state are cleared. After release, pixels are dropped until a line start arrives.
- R4: Items on a virtual channel whose enable bit is 0 produce no pixel output and leave the column and row counters unchanged.
- R5: A pixel word is accepted only when its data type is in an enabled class. The raw class covers only 0x2B (RAW10) and 0x2C (RAW12); any other raw type, such as 0x2A or 0x2D, is dropped. The YUV class covers 0x18 through 0x1F. A dropped pixel does not advance the column.
- R6: The item kind is encoded as 0 = frame start, 1 = line start, 2 = pixel word and 3 = frame end.
  - A frame start clears the row and column and leaves the line.
  - The first line start after it opens row 0, and each later line start adds one to the row. Every line start clears the column.
  - Each accepted pixel inside a line advances the column by one.
  - Pixels outside a line and frame-end items have no effect.
- R7: An accepted pixel at column x and row y is forwarded only when first column <= x <= last column and first row <= y <= last row, with both bounds inclusive.
- R8: A forwarded pixel appears on out_valid/out_data on the clock edge that samples it, with the same data word.
- R9: A frame start on a channel whose bit is set in the vertical selector gives a one-cycle out_vs pulse. A line start on a channel set in the horizontal selector gives a one-cycle out_hs pulse. Both pulses are independent of the channel reception enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| in_valid | input | 1 | Decoded item present |
| in_vc | input | log2(NUM_VC) | Virtual channel of the item |
| in_dt | input | 6 | Data type of the item |
| in_kind | input | 2 | Item kind: 0 frame start, 1 line start, 2 pixel, 3 frame end |
| in_data | input | PIX_W | Pixel word |
| out_valid | output | 1 | Forwarded pixel present |
| out_data | output | PIX_W | Forwarded pixel word |
| out_vs | output | 1 | Vertical sync pulse |
| out_hs | output | 1 | Horizontal sync pulse |

## Verification
Whole frames of several lines are sent through a rectangle that cuts pixels off on every side, and then through a single-pixel rectangle. This separates an inclusive bound from an off-by-one one and shows which counter drives which comparison. Foreign-channel items, a frame-end item and a pixel before the first line start are inserted into a live line; the forwarded positions expose any counter they wrongly disturb. A sweep of data types over both class enables shows the exact raw and YUV acceptance sets. Sync selectors pointing at disabled channels, and a soft reset issued mid-frame, show that sync pulses and counter clearing follow their own rules rather than the reception path.

// File: rtl/csi_crop_pkg.sv
package csi_crop_pkg;

   typedef enum logic [1:0] {
      K_FS  = 2'd0,
      K_LS  = 2'd1,
      K_PIX = 2'd2,
      K_FE  = 2'd3
   } pkt_kind_t;

   localparam logic [5:0] DT_RAW10  = 6'h2B;
   localparam logic [5:0] DT_RAW12  = 6'h2C;
   localparam logic [5:0] DT_YUV_LO = 6'h18;
   localparam logic [5:0] DT_YUV_HI = 6'h1F;

   localparam int A_CTRL = 'h00;
   localparam int A_GEN  = 'h04;
   localparam int A_XWIN = 'h0C;
   localparam int A_YWIN = 'h10;
   localparam int A_SEL  = 'h1C;

   typedef struct packed {
      logic        srst;
      logic        clk_en;
      logic [3:0]  vc_en;
      logic        raw_en;
      logic        yuv_en;
      logic [15:0] xs;
      logic [15:0] xe;
      logic [15:0] ys;
      logic [15:0] ye;
      logic [3:0]  vs_sel;
      logic [3:0]  hs_sel;
   } cfg_t;

endpackage

// File: rtl/csi_crop_regs.sv
module csi_crop_regs
   import csi_crop_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int NUM_VC = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [31:0]       wdata,
   output logic [31:0]       rdata,
   output cfg_t              cfg
);

   localparam logic [3:0] VC_MASK = 4'((1 << NUM_VC) - 1);

   logic [1:0]  ctrl_q;
   logic [3:0]  vcen_q;
   logic [4:0]  cls_q;
   logic [31:0] xwin_q;
   logic [31:0] ywin_q;
   logic [3:0]  vssel_q;
   logic [3:0]  hssel_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q  <= '0;
         vcen_q  <= '0;
         cls_q   <= '0;
         xwin_q  <= '0;
         ywin_q  <= '0;
         vssel_q <= '0;
         hssel_q <= '0;
      end else if (we) begin
         case (addr)
            ADDR_W'(A_CTRL): ctrl_q <= wdata[1:0];
            ADDR_W'(A_GEN): begin
               vcen_q <= wdata[3:0] & VC_MASK;
               cls_q  <= wdata[20:16];
            end
            ADDR_W'(A_XWIN): xwin_q <= wdata;
            ADDR_W'(A_YWIN): ywin_q <= wdata;
            ADDR_W'(A_SEL): begin
               vssel_q <= wdata[19:16] & VC_MASK;
               hssel_q <= wdata[23:20] & VC_MASK;
            end
            default: ;
         endcase
      end
   end

   always_comb begin
      rdata = '0;
      case (addr)
         ADDR_W'(A_CTRL): rdata[1:0] = ctrl_q;
         ADDR_W'(A_GEN): begin
            rdata[3:0]   = vcen_q;
            rdata[20:16] = cls_q;
         end
         ADDR_W'(A_XWIN): rdata = xwin_q;
         ADDR_W'(A_YWIN): rdata = ywin_q;
         ADDR_W'(A_SEL): begin
            rdata[19:16] = vssel_q;
            rdata[23:20] = hssel_q;
         end
         default: rdata = '0;
      endcase
   end

   always_comb begin
      cfg.srst   = ctrl_q[0];
      cfg.clk_en = ctrl_q[1];
      cfg.vc_en  = vcen_q;
      cfg.raw_en = cls_q[0];
      cfg.yuv_en = cls_q[1];
      cfg.xs     = xwin_q[15:0];
      cfg.xe     = xwin_q[31:16];
      cfg.ys     = ywin_q[15:0];
      cfg.ye     = ywin_q[31:16];
      cfg.vs_sel = vssel_q;
      cfg.hs_sel = hssel_q;
   end

endmodule

// File: rtl/csi_crop_class.sv
module csi_crop_class
   import csi_crop_pkg::*;
#(
   parameter int NUM_VC      = 4,
   parameter int VC_W        = 2,
   parameter bit YUV_SUPPORT = 1'b1
) (
   input  logic [NUM_VC-1:0] vc_en,
   input  logic [NUM_VC-1:0] vs_sel,
   input  logic [NUM_VC-1:0] hs_sel,
   input  logic              raw_en,
   input  logic              yuv_en,
   input  logic              in_valid,
   input  logic [VC_W-1:0]   in_vc,
   input  logic [5:0]        in_dt,
   input  logic [1:0]        in_kind,
   output logic              acc_fs,
   output logic              acc_ls,
   output logic              acc_pix,
   output logic              vs_hit,
   output logic              hs_hit
);

   logic [NUM_VC-1:0] vc_hit;
   logic              vc_ok;
   logic              raw_ok;
   logic              yuv_ok;
   logic              is_fs;
   logic              is_ls;
   logic              is_pix;

   for (genvar g = 0; g < NUM_VC; g++) begin : g_vc
      assign vc_hit[g] = (in_vc == VC_W'(g));
   end

   if (YUV_SUPPORT) begin : g_yuv
      assign yuv_ok = yuv_en && (in_dt >= DT_YUV_LO) && (in_dt <= DT_YUV_HI);
   end else begin : g_no_yuv
      assign yuv_ok = 1'b0;
   end

   assign raw_ok = raw_en && ((in_dt == DT_RAW10) || (in_dt == DT_RAW12));
   assign vc_ok  = |(vc_hit & vc_en);
   assign is_fs  = in_valid && (in_kind == K_FS);
   assign is_ls  = in_valid && (in_kind == K_LS);
   assign is_pix = in_valid && (in_kind == K_PIX);

   assign acc_fs  = is_fs && vc_ok;
   assign acc_ls  = is_ls && vc_ok;
   assign acc_pix = is_pix && vc_ok && (raw_ok || yuv_ok);
   assign vs_hit  = is_fs && (|(vc_hit & vs_sel));
   assign hs_hit  = is_ls && (|(vc_hit & hs_sel));

endmodule

// File: rtl/csi_crop_window.sv
module csi_crop_window #(
   parameter int CW    = 16,
   parameter int PIX_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             acc_fs,
   input  logic             acc_ls,
   input  logic             acc_pix,
   input  logic             vs_hit,
   input  logic             hs_hit,
   input  logic [PIX_W-1:0] in_data,
   input  logic [CW-1:0]    xs,
   input  logic [CW-1:0]    xe,
   input  logic [CW-1:0]    ys,
   input  logic [CW-1:0]    ye,
   output logic             out_valid,
   output logic [PIX_W-1:0] out_data,
   output logic             out_vs,
   output logic             out_hs
);

   logic [CW-1:0] x_q;
   logic [CW-1:0] y_q;
   logic          in_line_q;
   logic          win_hit;

   assign win_hit = in_line_q && (x_q >= xs) && (x_q <= xe) &&
                    (y_q >= ys) && (y_q <= ye);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         x_q       <= '0;
         y_q       <= '0;
         in_line_q <= 1'b0;
         out_valid <= 1'b0;
         out_data  <= '0;
         out_vs    <= 1'b0;
         out_hs    <= 1'b0;
      end else if (!run) begin
         x_q       <= '0;
         y_q       <= '0;
         in_line_q <= 1'b0;
         out_valid <= 1'b0;
         out_vs    <= 1'b0;
         out_hs    <= 1'b0;
      end else begin
         out_vs    <= vs_hit;
         out_hs    <= hs_hit;
         out_valid <= acc_pix && win_hit;
         if (acc_pix && win_hit) begin
            out_data <= in_data;
         end
         if (acc_fs) begin
            x_q       <= '0;
            y_q       <= '0;
            in_line_q <= 1'b0;
         end else if (acc_ls) begin
            x_q       <= '0;
            y_q       <= in_line_q ? y_q + 1'b1 : '0;
            in_line_q <= 1'b1;
         end else if (acc_pix && in_line_q) begin
            x_q <= x_q + 1'b1;
         end
      end
   end

endmodule

// File: rtl/csi_crop.sv
module csi_crop
   import csi_crop_pkg::*;
#(
   parameter int  NUM_VC      = 4,
   parameter int  CW          = 16,
   parameter int  PIX_W       = 12,
   parameter int  ADDR_W      = 8,
   parameter bit  YUV_SUPPORT = 1'b1,
   localparam int VC_W        = $clog2(NUM_VC)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   input  logic              in_valid,
   input  logic [VC_W-1:0]   in_vc,
   input  logic [5:0]        in_dt,
   input  logic [1:0]        in_kind,
   input  logic [PIX_W-1:0]  in_data,
   output logic              out_valid,
   output logic [PIX_W-1:0]  out_data,
   output logic              out_vs,
   output logic              out_hs
);

   if (NUM_VC < 2 || NUM_VC > 4) begin : g_bad_vc
      $error("csi_crop: NUM_VC must be 2..4");
   end
   if (CW < 1 || CW > 16) begin : g_bad_cw
      $error("csi_crop: CW must be 1..16");
   end
   if (ADDR_W < 5) begin : g_bad_addr
      $error("csi_crop: ADDR_W must be at least 5");
   end
   if (PIX_W < 1) begin : g_bad_pix
      $error("csi_crop: PIX_W must be positive");
   end

   cfg_t cfg;
   logic run;
   logic acc_fs;
   logic acc_ls;
   logic acc_pix;
   logic vs_hit;
   logic hs_hit;

   assign run = !cfg.srst && cfg.clk_en;

   csi_crop_regs #(
      .ADDR_W (ADDR_W),
      .NUM_VC (NUM_VC)
   ) u_regs (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (reg_we),
      .addr  (reg_addr),
      .wdata (reg_wdata),
      .rdata (reg_rdata),
      .cfg   (cfg)
   );

   csi_crop_class #(
      .NUM_VC      (NUM_VC),
      .VC_W        (VC_W),
      .YUV_SUPPORT (YUV_SUPPORT)
   ) u_class (
      .vc_en    (cfg.vc_en[NUM_VC-1:0]),
      .vs_sel   (cfg.vs_sel[NUM_VC-1:0]),
      .hs_sel   (cfg.hs_sel[NUM_VC-1:0]),
      .raw_en   (cfg.raw_en),
      .yuv_en   (cfg.yuv_en),
      .in_valid (in_valid),
      .in_vc    (in_vc),
      .in_dt    (in_dt),
      .in_kind  (in_kind),
      .acc_fs   (acc_fs),
      .acc_ls   (acc_ls),
      .acc_pix  (acc_pix),
      .vs_hit   (vs_hit),
      .hs_hit   (hs_hit)
   );

   csi_crop_window #(
      .CW    (CW),
      .PIX_W (PIX_W)
   ) u_win (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (run),
      .acc_fs    (acc_fs),
      .acc_ls    (acc_ls),
      .acc_pix   (acc_pix),
      .vs_hit    (vs_hit),
      .hs_hit    (hs_hit),
      .in_data   (in_data),
      .xs        (cfg.xs[CW-1:0]),
      .xe        (cfg.xe[CW-1:0]),
      .ys        (cfg.ys[CW-1:0]),
      .ye        (cfg.ye[CW-1:0]),
      .out_valid (out_valid),
      .out_data  (out_data),
      .out_vs    (out_vs),
      .out_hs    (out_hs)
   );

endmodule

// File: rtl/csi_crop_chk.sv
module csi_crop_chk
   import csi_crop_pkg::*;
#(
   parameter int PIX_W = 12
) (
   input logic             clk,
   input logic             rst_n,
   input logic             run,
   input logic             in_valid,
   input logic [1:0]       in_kind,
   input logic [PIX_W-1:0] in_data,
   input logic             out_valid,
   input logic [PIX_W-1:0] out_data,
   input logic             out_vs,
   input logic             out_hs
);

   p_idle_silent_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (!out_valid && !out_vs && !out_hs));

   p_pix_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $past(in_valid && (in_kind == K_PIX)));

   p_pix_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_data == $past(in_data)));

   p_vs_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
      out_vs |-> $past(in_valid && (in_kind == K_FS)));

   p_hs_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
      out_hs |-> $past(in_valid && (in_kind == K_LS)));

   p_sync_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(out_vs && out_hs));

endmodule

bind csi_crop csi_crop_chk #(.PIX_W(PIX_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .run       (run),
   .in_valid  (in_valid),
   .in_kind   (in_kind),
   .in_data   (in_data),
   .out_valid (out_valid),
   .out_data  (out_data),
   .out_vs    (out_vs),
   .out_hs    (out_hs)
);

// File: tb/sim_csi_crop.sv
`timescale 1ns/1ps
module sim_csi_crop;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [7:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        in_valid = 1'b0;
   logic [1:0]  in_vc = '0;
   logic [5:0]  in_dt = '0;
   logic [1:0]  in_kind = '0;
   logic [11:0] in_data = '0;
   logic        out_valid;
   logic [11:0] out_data;
   logic        out_vs;
   logic        out_hs;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   csi_crop u0 (
      .clk (clk), .rst_n (rst_n),
      .reg_we (reg_we), .reg_addr (reg_addr), .reg_wdata (reg_wdata), .reg_rdata (reg_rdata),
      .in_valid (in_valid), .in_vc (in_vc), .in_dt (in_dt), .in_kind (in_kind), .in_data (in_data),
      .out_valid (out_valid), .out_data (out_data), .out_vs (out_vs), .out_hs (out_hs)
   );

   // bench model of configuration and position
   logic        m_srst = 0, m_clken = 0, m_raw = 0, m_yuv = 0;
   logic [3:0]  m_vcen = 0, m_vssel = 0, m_hssel = 0;
   logic [15:0] m_xs = 0, m_xe = 0, m_ys = 0, m_ye = 0;
   logic [15:0] m_x = 0, m_y = 0;
   logic        m_inl = 0;

   logic [14:0] exp_q[$];
   string       tag_q[$];

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      in_valid = 1'b0; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      case (a)
         8'h00: begin m_srst = d[0]; m_clken = d[1]; end
         8'h04: begin m_vcen = d[3:0]; m_raw = d[16]; m_yuv = d[17]; end
         8'h0C: begin m_xs = d[15:0]; m_xe = d[31:16]; end
         8'h10: begin m_ys = d[15:0]; m_ye = d[31:16]; end
         8'h1C: begin m_vssel = d[19:16]; m_hssel = d[23:20]; end
         default: ;
      endcase
      if (m_srst || !m_clken) begin m_x = 0; m_y = 0; m_inl = 0; end
   endtask

   task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
      @(negedge clk);
      in_valid = 1'b0; reg_we = 1'b0; reg_addr = a;
      #1;
      total++;
      if (reg_rdata !== e) begin
         bad++;
         $display("FAIL %s: reg 0x%02h actual=0x%08h expected=0x%08h", tag, a, reg_rdata, e);
      end
   endtask

   task automatic pkt(input int vc, input logic [5:0] dt, input logic [1:0] kind,
                      input logic [11:0] d, input string tag);
      logic ev, evs, ehs, vok, cls, win;
      logic [11:0] ed;
      @(negedge clk);
      reg_we = 1'b0; in_valid = 1'b1; in_vc = vc[1:0]; in_dt = dt; in_kind = kind; in_data = d;
      ev = 0; evs = 0; ehs = 0; ed = '0;
      if (m_srst || !m_clken) begin
         m_x = 0; m_y = 0; m_inl = 0;
      end else begin
         vok = m_vcen[vc];
         case (kind)
            2'd0: begin
               if (vok) begin m_x = 0; m_y = 0; m_inl = 0; end
               evs = m_vssel[vc];
            end
            2'd1: begin
               if (vok) begin m_y = m_inl ? m_y + 16'd1 : 16'd0; m_x = 0; m_inl = 1; end
               ehs = m_hssel[vc];
            end
            2'd2: begin
               cls = (m_raw && (dt == 6'h2B || dt == 6'h2C)) ||
                     (m_yuv && dt >= 6'h18 && dt <= 6'h1F);
               if (vok && cls && m_inl) begin
                  win = (m_x >= m_xs) && (m_x <= m_xe) && (m_y >= m_ys) && (m_y <= m_ye);
                  if (win) begin ev = 1; ed = d; end
                  m_x = m_x + 16'd1;
               end
            end
            default: ;
         endcase
      end
      exp_q.push_back({ev, evs, ehs, ed});
      tag_q.push_back(tag);
   endtask

   task automatic line(input int vc, input int n, input logic [11:0] base, input string tag);
      pkt(vc, 6'h00, 2'd1, 12'd0, tag);
      for (int i = 0; i < n; i++) pkt(vc, 6'h2B, 2'd2, base + 12'(i), tag);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         in_valid = 1'b0; reg_we = 1'b0;
      end
   endtask

   // monitor: pops the expectation of the item driven one edge earlier
   initial begin
      logic [14:0] e, g;
      string t;
      forever begin
         @(posedge clk);
         #1;
         if (exp_q.size() > 0) begin
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            g = {out_valid, out_vs, out_hs, e[14] ? out_data : 12'd0};
            total++;
            if (g !== e) begin
               bad++;
               $display("FAIL %s: {valid,vs,hs,data} actual=%b/%b/%b/0x%03h expected=%b/%b/%b/0x%03h",
                        t, g[14], g[13], g[12], g[11:0], e[14], e[13], e[12], e[11:0]);
            end
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      idle(1);
      #1;
      total++;
      if ({out_valid, out_vs, out_hs} !== 3'b000) begin
         bad++;
         $display("FAIL R1: outputs actual=%b expected=000", {out_valid, out_vs, out_hs});
      end
      rd(8'h00, 32'h0, "R1"); rd(8'h04, 32'h0, "R1"); rd(8'h0C, 32'h0, "R1");
      rd(8'h10, 32'h0, "R1"); rd(8'h1C, 32'h0, "R1");

      // clock enable off: everything dropped
      wr(8'h1C, 32'h0011_0000);
      wr(8'h04, 32'h0001_0001);
      wr(8'h0C, 32'hFFFF_0000);
      wr(8'h10, 32'hFFFF_0000);
      pkt(0, 6'h00, 2'd0, 12'd0, "R3 clock off");
      line(0, 3, 12'h100, "R3 clock off");

      // register layout and reserved bits
      wr(8'h00, 32'hFFFF_FFFE);
      rd(8'h00, 32'h0000_0002, "R2");
      wr(8'h04, 32'hFFFF_FFFF);
      rd(8'h04, 32'h001F_000F, "R2");
      wr(8'h1C, 32'hFFFF_FFFF);
      rd(8'h1C, 32'h00FF_0000, "R2");
      wr(8'h0C, 32'h0005_0002);
      rd(8'h0C, 32'h0005_0002, "R2");
      wr(8'h10, 32'h0002_0001);
      rd(8'h10, 32'h0002_0001, "R2");
      wr(8'h1C, 32'h0011_0000);
      wr(8'h04, 32'h0001_0001);

      // cropped frame
      pkt(0, 6'h00, 2'd0, 12'd0, "R9 vs on selected channel");
      pkt(0, 6'h2B, 2'd2, 12'h0AA, "R6 pixel before first line");
      line(0, 8, 12'h000, "R7 crop row 0");
      pkt(0, 6'h00, 2'd1, 12'd0, "R9 hs on selected channel");
      for (int i = 0; i < 3; i++) pkt(0, 6'h2C, 2'd2, 12'h010 + 12'(i), "R7 crop row 1");
      pkt(1, 6'h00, 2'd1, 12'd0, "R4 disabled channel line start");
      for (int i = 0; i < 3; i++) pkt(1, 6'h2B, 2'd2, 12'h0F0 + 12'(i), "R4 disabled channel pixel");
      for (int i = 3; i < 8; i++) pkt(0, 6'h2B, 2'd2, 12'h010 + 12'(i), "R4 R7 crop row 1");
      pkt(0, 6'h00, 2'd1, 12'd0, "R6 row 2");
      for (int i = 0; i < 3; i++) pkt(0, 6'h2B, 2'd2, 12'h020 + 12'(i), "R7 crop row 2");
      pkt(0, 6'h00, 2'd3, 12'd0, "R6 frame end ignored");
      for (int i = 3; i < 8; i++) pkt(0, 6'h2B, 2'd2, 12'h020 + 12'(i), "R6 R7 crop row 2");
      line(0, 8, 12'h030, "R7 crop row 3");
      idle(2);

      // data type classes
      wr(8'h0C, 32'hFFFF_0000);
      wr(8'h10, 32'hFFFF_0000);
      pkt(0, 6'h00, 2'd0, 12'd0, "R5 frame");
      pkt(0, 6'h00, 2'd1, 12'd0, "R5 line");
      pkt(0, 6'h2B, 2'd2, 12'h201, "R5 raw10");
      pkt(0, 6'h2C, 2'd2, 12'h202, "R5 raw12");
      pkt(0, 6'h2A, 2'd2, 12'h203, "R5 raw8 dropped");
      pkt(0, 6'h2D, 2'd2, 12'h204, "R5 raw14 dropped");
      pkt(0, 6'h1E, 2'd2, 12'h205, "R5 yuv with class off");
      pkt(0, 6'h12, 2'd2, 12'h206, "R5 other type dropped");
      wr(8'h0C, 32'h0003_0002);
      pkt(0, 6'h2C, 2'd2, 12'h207, "R5 dropped pixels keep column");
      pkt(0, 6'h2C, 2'd2, 12'h208, "R5 column 3");
      pkt(0, 6'h2C, 2'd2, 12'h209, "R5 column 4 outside");
      wr(8'h0C, 32'hFFFF_0000);
      wr(8'h04, 32'h0003_0001);
      pkt(0, 6'h1E, 2'd2, 12'h20A, "R5 yuv 0x1E");
      pkt(0, 6'h18, 2'd2, 12'h20B, "R5 yuv 0x18");
      pkt(0, 6'h1F, 2'd2, 12'h20C, "R5 yuv 0x1F");
      pkt(0, 6'h17, 2'd2, 12'h20D, "R5 below yuv range");
      pkt(0, 6'h20, 2'd2, 12'h20E, "R5 above yuv range");
      wr(8'h04, 32'h0002_0001);
      pkt(0, 6'h2B, 2'd2, 12'h20F, "R5 raw class off");
      pkt(0, 6'h19, 2'd2, 12'h210, "R5 yuv only");
      idle(2);

      // sync selectors
      wr(8'h04, 32'h0001_0001);
      wr(8'h1C, 32'h0084_0000);
      pkt(0, 6'h00, 2'd0, 12'd0, "R9 vs not selected");
      pkt(2, 6'h00, 2'd0, 12'd0, "R9 vs from disabled selected channel");
      pkt(3, 6'h00, 2'd1, 12'd0, "R9 hs from channel 3");
      pkt(0, 6'h00, 2'd1, 12'd0, "R9 hs not selected");
      pkt(0, 6'h2B, 2'd2, 12'h301, "R4 vc0 pixel after foreign syncs");
      idle(2);

      // soft reset
      wr(8'h1C, 32'h0011_0000);
      wr(8'h00, 32'h0000_0003);
      pkt(0, 6'h2B, 2'd2, 12'h401, "R3 soft reset pixel");
      pkt(0, 6'h00, 2'd0, 12'd0, "R3 soft reset vs");
      pkt(0, 6'h00, 2'd1, 12'd0, "R3 soft reset hs");
      wr(8'h00, 32'h0000_0002);
      pkt(0, 6'h2B, 2'd2, 12'h402, "R3 counters cleared");
      line(0, 2, 12'h403, "R3 after release");
      idle(2);

      // single-pixel window and latency
      wr(8'h0C, 32'h0003_0003);
      wr(8'h10, 32'h0001_0001);
      pkt(0, 6'h00, 2'd0, 12'd0, "R7 single frame");
      line(0, 6, 12'h500, "R7 single row 0");
      line(0, 6, 12'h510, "R7 R8 single row 1");
      line(0, 6, 12'h520, "R7 single row 2");
      wr(8'h0C, 32'h0004_0002);
      wr(8'h10, 32'h0002_0000);
      pkt(0, 6'h00, 2'd0, 12'd0, "R6 new frame");
      line(0, 6, 12'h600, "R6 R7 row 0");
      line(0, 6, 12'h610, "R7 row 1");
      line(0, 6, 12'h620, "R7 row 2");
      line(0, 6, 12'h630, "R7 row 3 outside");
      idle(4);

      total++;
      if (exp_q.size() != 0) begin
         bad++;
         $display("FAIL R8: pending expectations actual=%0d expected=0", exp_q.size());
      end
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule